// File: doc/BRIEF.md
# Dual-Channel Interval Pulse Generator

This block derives periodic output pulses, such as a once-per-second marker, from a free-running precision time counter. The time counter supplies a carry strobe for each step. Each step advances time by a nominal period expressed in nanoseconds. The block has two independent channels. Each channel holds a countdown in nanoseconds. On every counter carry, the countdown shrinks by the nominal period. When the remaining amount drops below one period, the channel fires and reloads its programmed interval.

Each firing does two things. It raises the channel's pulse output, which lasts until the next edge of the prescaled output clock. That edge is given to the block as a one-cycle tick strobe. It also raises a one-cycle event strobe.

The interval is programmed as the wanted period in nanoseconds minus one nominal period. With a 10 ns step, the value 999,999,990 gives exactly one pulse per second. The value 99,990 gives one pulse every 100,000 ns.

Top module: `interval_pulse_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, both `pulse_o` and `event_o` are low after that edge. Each channel's countdown is cleared, so the first enabled carry after reset fires that channel.
- R2: For an enabled channel with interval I and period P (P > 0), consecutive firings are exactly floor(I/P)+1 carries apart. An interval of (N-1)·P therefore yields one firing every N carries, for example 999,999,990 at P = 10 gives 100,000,000 carries.
- R3: Clock edges without `carry_i` high leave the countdown unchanged and never produce an event. An event appears only after an edge at which `carry_i` and the channel's enable were both high.
- R4: A firing at clock edge k makes `event_o` high for the cycle after edge k. `pulse_o` is high in that same cycle.
- R5: After a firing, `pulse_o` stays high until the first later edge at which `tick_i` is high. It is low in the cycle after that edge.
- R6: A `tick_i` present at the very edge where a channel fires does not end that channel's pulse.
- R7: A new interval value written while a channel is counting is used only at that channel's next reload. The interval already in progress keeps its length.
- R8: While a channel's enable bit (bit k of `en_i`) is low, the channel's `pulse_o` and `event_o` are low. Its countdown follows the interval input. After re-enabling, the first firing comes after floor(I/P)+1 carries.
- R9: The channels share `carry_i`, `tick_i` and `period_i` but are otherwise independent. Channel k uses bits [k·W +: W] of `interval_i` and bit k of each per-channel vector.
- R10: A channel firing while its pulse is already high keeps `pulse_o` high and raises a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| carry_i | input | 1 | One-cycle strobe per time-counter step |
| tick_i | input | 1 | One-cycle strobe at each prescaled output clock edge |
| en_i | input | NCH | Per-channel enable |
| period_i | input | W | Nominal step in nanoseconds |
| interval_i | input | NCH·W | Per-channel interval, channel k in bits [k·W +: W] |
| pulse_o | output | NCH | Per-channel pulse output |
| event_o | output | NCH | Per-channel one-cycle firing strobe |

## Verification
The bench aims at the following corner cases:

- **Mid-interval interval write.** A design that loads the new value at once would shift the next event, and the scoreboard would see the wrong cycle.
- **Interval that is not a multiple of the period.** An off-by-one in the "below one period" test would add or drop a carry between firings.
- **Tick on the firing edge.** A design that lets that tick win would report an event with `pulse_o` low.
- **Interval smaller than the period.** The channel must fire on every carry with the pulse held high throughout. A design that toggled the pulse would fail here.
- **Disable and re-enable, plus the first carry after reset.** A stale countdown on re-enable, or one that is not cleared at reset, would misplace the first event.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int unsigned IPG_W_DEF   = 32;
  localparam int unsigned IPG_NCH_DEF = 2;

  typedef struct packed {
    logic pulse;
    logic evt;
  } ipg_out_t;
endpackage

// File: rtl/ipg_countdown.sv
module ipg_countdown #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic         carry_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] interval_i,
  output logic         fire_o
);
  logic [W-1:0] remain_q;
  logic         short_w;

  // less than one step left: this carry ends the interval
  assign short_w = (remain_q < period_i);
  assign fire_o  = en_i && carry_i && short_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      remain_q <= '0;
    end else if (!en_i) begin
      remain_q <= interval_i;
    end else if (carry_i) begin
      if (short_w) remain_q <= interval_i;
      else         remain_q <= remain_q - period_i;
    end
  end
endmodule

// File: rtl/ipg_shaper.sv
module ipg_shaper
  import ipg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     en_i,
  input  logic     fire_i,
  input  logic     tick_i,
  output ipg_out_t out_o
);
  ipg_out_t out_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      out_q <= '0;
    end else begin
      out_q.evt <= fire_i;
      if (fire_i)      out_q.pulse <= 1'b1;
      else if (tick_i) out_q.pulse <= 1'b0;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen
  import ipg_pkg::*;
#(
  parameter int unsigned W   = IPG_W_DEF,
  parameter int unsigned NCH = IPG_NCH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             carry_i,
  input  logic             tick_i,
  input  logic [NCH-1:0]   en_i,
  input  logic [W-1:0]     period_i,
  input  logic [NCH*W-1:0] interval_i,
  output logic [NCH-1:0]   pulse_o,
  output logic [NCH-1:0]   event_o
);
  localparam int unsigned IW = NCH * W;

  logic [NCH-1:0] fire_w;
  ipg_out_t       ch_out [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    ipg_countdown #(.W(W)) u_cnt (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .en_i       (en_i[k]),
      .carry_i    (carry_i),
      .period_i   (period_i),
      .interval_i (interval_i[k*W +: W]),
      .fire_o     (fire_w[k])
    );

    ipg_shaper u_shp (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i[k]),
      .fire_i (fire_w[k]),
      .tick_i (tick_i),
      .out_o  (ch_out[k])
    );

    assign pulse_o[k] = ch_out[k].pulse;
    assign event_o[k] = ch_out[k].evt;
  end

  if (IW == 0) begin : g_bad
    initial $error("interval bus must not be empty");
  end
endmodule

// File: rtl/ipg_checker.sv
module ipg_checker #(
  parameter int unsigned NCH = 2
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           carry_i,
  input logic           tick_i,
  input logic [NCH-1:0] en_i,
  input logic [NCH-1:0] pulse_o,
  input logic [NCH-1:0] event_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (pulse_o == '0 && event_o == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    assert_event_needs_carry_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      event_o[k] |-> ($past(carry_i) && $past(en_i[k])));

    assert_event_with_pulse_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      event_o[k] |-> pulse_o[k]);

    assert_rise_with_event_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pulse_o[k]) |-> event_o[k]);

    assert_fall_on_tick_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(pulse_o[k]) |-> ($past(tick_i) || !$past(en_i[k])));

    assert_quiet_disabled_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(en_i[k]) |-> (!pulse_o[k] && !event_o[k]));
  end
endmodule

bind interval_pulse_gen ipg_checker #(.NCH(NCH)) u_ipg_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .carry_i (carry_i),
  .tick_i  (tick_i),
  .en_i    (en_i),
  .pulse_o (pulse_o),
  .event_o (event_o)
);

// File: tb/interval_pulse_gen_tb_top.sv
module interval_pulse_gen_tb_top;
  localparam int unsigned W   = 32;
  localparam int unsigned NCH = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic           carry;
  logic           tick;
  logic [NCH-1:0] en;
  logic [W-1:0]   period;
  logic [W-1:0]   iv0;
  logic [W-1:0]   iv1;
  logic [NCH-1:0] pulse;
  logic [NCH-1:0] evt;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  longint left [NCH];
  logic   xp   [NCH];
  int     q0 [$];
  int     q1 [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interval_pulse_gen #(.W(W), .NCH(NCH)) dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .carry_i    (carry),
    .tick_i     (tick),
    .en_i       (en),
    .period_i   (period),
    .interval_i ({iv1, iv0}),
    .pulse_o    (pulse),
    .event_o    (evt)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model: counts carries to the next firing, per requirements R1..R10
  task automatic model();
    for (int k = 0; k < NCH; k++) begin
      logic [W-1:0] iv;
      longint       reload;
      logic         fire;
      iv     = (k == 0) ? iv0 : iv1;
      reload = longint'(iv / period) + 1;
      if (rst) begin
        left[k] = 1; xp[k] = 1'b0;
      end else if (!en[k]) begin
        left[k] = reload; xp[k] = 1'b0;
      end else begin
        fire = carry && (left[k] == 1);
        if (carry) left[k] = fire ? reload : left[k] - 1;
        if (fire) begin
          xp[k] = 1'b1;
          if (k == 0) q0.push_back(cyc); else q1.push_back(cyc);
        end else if (tick) begin
          xp[k] = 1'b0;
        end
      end
    end
  endtask

  // Driver: account for the edge just taken, then set inputs for the next one
  task automatic step(input logic c, input logic t);
    @(posedge clk);
    #5;
    model();
    carry = c;
    tick  = t;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (cyc > 0) begin
      for (int k = 0; k < NCH; k++) begin
        checks++;
        if (pulse[k] !== xp[k]) begin
          errors++;
          $display("FAIL %s ch%0d pulse: actual %0b expected %0b (cycle %0d)", cur_req, k, pulse[k], xp[k], cyc);
        end
        if (evt[k] === 1'b1) begin
          checks++;
          if (k == 0 ? q0.size() == 0 : q1.size() == 0) begin
            errors++;
            $display("FAIL %s ch%0d event: actual cycle %0d expected none", cur_req, k, cyc);
          end else begin
            int e;
            e = (k == 0) ? q0.pop_front() : q1.pop_front();
            if (e != cyc) begin
              errors++;
              $display("FAIL %s ch%0d event: actual cycle %0d expected %0d", cur_req, k, cyc, e);
            end
          end
        end else if (k == 0 ? (q0.size() > 0 && q0[0] <= cyc) : (q1.size() > 0 && q1[0] <= cyc)) begin
          int e;
          checks++;
          errors++;
          e = (k == 0) ? q0.pop_front() : q1.pop_front();
          $display("FAIL %s ch%0d event: actual missing expected %0d", cur_req, k, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; carry = 1'b0; tick = 1'b0; en = 2'b11;
    period = 10; iv0 = 30; iv1 = 50;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    chk(pulse == 2'b00 && evt == 2'b00, "R1 outputs in reset", {pulse, evt}, 0);

    // R1: first carry after reset fires both channels
    rst = 1'b0;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk(evt == 2'b11, "R1 first carry fires", evt, 3);

    // R2/R3/R9: carries with gaps, ticks out of phase, two different intervals
    cur_req = "R2";
    for (int i = 0; i < 90; i++) step(i % 3 == 0, i % 5 == 0);

    // R6: tick on every edge, including every firing edge
    cur_req = "R6";
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1);

    // R7: interval rewritten part-way through
    cur_req = "R7";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    iv0 = 70;
    for (int i = 0; i < 60; i++) step(i % 2 == 0, i % 7 == 0);

    // R8: disable, rewrite, re-enable
    cur_req = "R8";
    en[0] = 1'b0;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
    chk(pulse[0] == 1'b0 && evt[0] == 1'b0, "R8 quiet while disabled", {pulse[0], evt[0]}, 0);
    iv0 = 20;
    step(1'b1, 1'b0);
    en[0] = 1'b1;
    for (int i = 0; i < 30; i++) step(1'b1, i % 4 == 0);

    // R10: interval below one period, fires on every carry
    cur_req = "R10";
    iv1 = 5;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    chk(pulse[1] == 1'b1 && evt[1] == 1'b1, "R10 held high with events", {pulse[1], evt[1]}, 3);

    // R5/R9: pseudo-random strobes, non-multiple intervals (R2 remainder case)
    cur_req = "R5";
    period = 8; iv0 = 100; iv1 = 37;
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3] & lfsr[5]);
    end

    cur_req = "R3";
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
    chk(evt == 2'b00, "R3 no event without carry", evt, 0);
    chk(q0.size() == 0 && q1.size() == 0, "R2 all expected events seen", q0.size() + q1.size(), 0);
    finish_run();
  end
endmodule